// File: doc/BRIEF.md
# Ping-Pong Capture Deinterleaver

The block receives a stream of interleaved 32-bit audio words, one word per enabled serial lane in each group. It stores them in a circular capture memory that is split into two equal halves. The write pointer advances by one on every accepted word and returns to zero after the last location. A one-cycle event marks the moment the pointer moves into the upper half, and a second event marks the moment it wraps back to the start.

On either event the drain side reads out the half that does not hold the live write pointer. Each word leaves on a valid/ready stream, tagged with the audio channel it belongs to and with its sample position in a per-channel destination buffer. Within a half, groups alternate between the left slot and the right slot. A word from lane i belongs to channel 2i when it sits in a left group and to channel 2i+1 when it sits in a right group.

A running destination offset advances by one half's worth of samples per channel after each completed drain, modulo the channel buffer length. When that advance would overtake the consumer's current read position, the drain is skipped and a sticky flag is raised. A second sticky flag records any event that arrives while a drain is still in progress.

Top module: `ppcap_deint`

## Requirements
- R1: Accepted words are stored at consecutive addresses from 0 to DEPTH-1 (DEPTH = GROUPS*LANES), and the pointer returns to 0 after address DEPTH-1. Every stored word reappears unchanged on `out_word`.
- R2: `half_evt` is high for exactly one cycle, in the cycle after the word at address DEPTH/2-1 is written. `wrap_evt` is high for exactly one cycle, in the cycle after the word at address DEPTH-1 is written.
- R3: On an event while idle, the block drains the half that does not hold the write pointer. It starts in the next cycle and outputs the DEPTH/2 words of that half in ascending address order, with `out_valid` high throughout.
- R4: Word k of a drained half has lane = k mod LANES and group g = k div LANES. Its `out_chan` is 2*lane + (g mod 2): even groups are left and odd groups are right. GROUPS must be a multiple of 4, so every half starts on a left group.
- R5: `out_sample` of word k equals (offset + g div 2) mod CH_LEN, where offset is the destination offset held during that drain.
- R6: The offset starts at 0. It advances by GROUPS/4 modulo CH_LEN when the last word of a drain is accepted, and stays unchanged when a drain is skipped.
- R7: If offset < `rd_pos` and offset + GROUPS/4 >= `rd_pos` at an idle event, no word is output and `skip_flag` sets and stays set until reset.
- R8: While `out_valid` is high and `out_ready` is low, `out_word`, `out_chan` and `out_sample` hold their values.
- R9: An event that arrives while a drain is in progress (including the cycle of its last transfer) sets `overrun_flag`, which stays set until reset. The event is otherwise ignored.
- R10: A write aimed at the half currently being drained is discarded, so the memory keeps its old word there, but the write pointer still advances.
- R11: After reset, `out_valid`, `half_evt`, `wrap_evt`, `skip_flag` and `overrun_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming word present this cycle |
| in_word | input | WORD_W | Incoming interleaved word |
| rd_pos | input | clog2(CH_LEN) | Consumer read position in the channel buffers |
| half_evt | output | 1 | Pulse: pointer entered the upper half |
| wrap_evt | output | 1 | Pulse: pointer wrapped to address 0 |
| out_valid | output | 1 | Drained word available |
| out_ready | input | 1 | Consumer accepts the drained word |
| out_word | output | WORD_W | Drained word |
| out_chan | output | clog2(LANES)+1 | Audio channel index of the word |
| out_sample | output | clog2(CH_LEN) | Sample position in that channel's buffer |
| skip_flag | output | 1 | Sticky: a drain was skipped to protect the reader |
| overrun_flag | output | 1 | Sticky: an event arrived during a drain |

## Verification
The assertions assume that the consumer may stall at any time but never withdraws `out_ready` expectations from a held word. They also assume that the writer delivers at least DEPTH/2 words between events, which the write-pointer logic guarantees. The stimulus keeps the writer slower than the drain in the normal phase, so every half is drained before the writer returns to it. It holds `rd_pos` just ahead of the offset in a dedicated phase to force skips. In a final phase it deliberately starves `out_ready` while writing every cycle, which drives the block into its overrun and discarded-write behaviour.

// File: rtl/ppcap_pkg.sv
package ppcap_pkg;

   // Index width for a count of n items; never below one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic {
      DR_IDLE = 1'b0,
      DR_RUN  = 1'b1
   } drain_st_e;

endpackage

// File: rtl/ppcap_wr_ctrl.sv
module ppcap_wr_ctrl #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          busy,
   input  logic          drain_hi,
   output logic [AW-1:0] wp,
   output logic          wp_hi,
   output logic          wr_en,
   output logic          half_evt,
   output logic          wrap_evt
);
   localparam int HALF = DEPTH / 2;

   logic [AW-1:0] wp_q;
   logic          at_mid, at_end;

   assign wp     = wp_q;
   assign wp_hi  = (wp_q >= AW'(HALF));
   assign at_mid = (wp_q == AW'(HALF - 1));
   assign at_end = (wp_q == AW'(DEPTH - 1));
   // R10: the half under drain is frozen; the pointer still moves on.
   assign wr_en  = in_valid && !(busy && (wp_hi == drain_hi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q     <= '0;
         half_evt <= 1'b0;
         wrap_evt <= 1'b0;
      end else begin
         half_evt <= in_valid && at_mid;
         wrap_evt <= in_valid && at_end;
         if (in_valid) wp_q <= at_end ? '0 : wp_q + 1'b1;
      end
   end

   p_evt_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(half_evt && wrap_evt));
   p_half_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      half_evt |=> !half_evt);
   p_wrap_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> !wrap_evt);
   p_ptr_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wp_q == AW'(DEPTH - 1)) |=> (wp_q == '0));

endmodule

// File: rtl/ppcap_mem.sv
module ppcap_mem #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 16,
   parameter int AW     = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/ppcap_drain.sv
module ppcap_drain
   import ppcap_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int GROUPS = 8,
   parameter int CH_LEN = 16,
   parameter int AW     = 4,
   parameter int LANE_W = 1,
   parameter int GW     = 2,
   parameter int POS_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_evt,
   input  logic              wrap_evt,
   input  logic              wp_hi,
   input  logic [POS_W-1:0]  rd_pos,
   input  logic              out_ready,
   output logic              busy,
   output logic              drain_hi,
   output logic [AW-1:0]     raddr,
   output logic              out_valid,
   output logic [LANE_W:0]   out_chan,
   output logic [POS_W-1:0]  out_sample,
   output logic              skip_flag,
   output logic              overrun_flag
);
   localparam int HALF = GROUPS * LANES / 2;
   localparam int HG   = GROUPS / 2;
   localparam int SPH  = GROUPS / 4;

   drain_st_e         st_q;
   logic              hi_q, skip_q, ovr_q;
   logic [AW-1:0]     k_q;
   logic [LANE_W-1:0] lane_q;
   logic [GW-1:0]     grp_q;
   logic [POS_W-1:0]  off_q, off_w, samp_w;
   logic [POS_W:0]    off_plus;
   logic              evt, lane_end, last, fire, clash;

   assign busy      = (st_q == DR_RUN);
   assign drain_hi  = hi_q;
   assign evt       = half_evt || wrap_evt;
   assign lane_end  = (lane_q == LANE_W'(LANES - 1));
   assign last      = lane_end && (grp_q == GW'(HG - 1));
   assign fire      = busy && out_ready;
   assign off_plus  = {1'b0, off_q} + (POS_W+1)'(SPH);
   // R7: the next advance would run past the reader.
   assign clash     = ({1'b0, off_q} < {1'b0, rd_pos}) && (off_plus >= {1'b0, rd_pos});

   // Modulo arithmetic for the channel buffer: free for a power of two.
   generate
      if ((CH_LEN & (CH_LEN - 1)) == 0) begin : g_pow2
         assign samp_w = off_q + POS_W'(grp_q >> 1);
         assign off_w  = off_q + POS_W'(SPH);
      end else begin : g_sub
         logic [POS_W:0] samp_sum;
         assign samp_sum = {1'b0, off_q} + (POS_W+1)'(grp_q >> 1);
         assign samp_w = (samp_sum >= (POS_W+1)'(CH_LEN)) ?
                         POS_W'(samp_sum - (POS_W+1)'(CH_LEN)) : POS_W'(samp_sum);
         assign off_w  = (off_plus >= (POS_W+1)'(CH_LEN)) ?
                         POS_W'(off_plus - (POS_W+1)'(CH_LEN)) : POS_W'(off_plus);
      end
   endgenerate

   assign raddr        = hi_q ? (k_q + AW'(HALF)) : k_q;
   assign out_valid    = busy;
   assign out_chan     = {lane_q, grp_q[0]};
   assign out_sample   = samp_w;
   assign skip_flag    = skip_q;
   assign overrun_flag = ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= DR_IDLE;
         hi_q   <= 1'b0;
         k_q    <= '0;
         lane_q <= '0;
         grp_q  <= '0;
         off_q  <= '0;
         skip_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (evt && busy) ovr_q <= 1'b1;
         if (evt && !busy) begin
            if (clash) begin
               skip_q <= 1'b1;
            end else begin
               st_q   <= DR_RUN;
               hi_q   <= !wp_hi;
               k_q    <= '0;
               lane_q <= '0;
               grp_q  <= '0;
            end
         end
         if (fire) begin
            if (last) begin
               st_q  <= DR_IDLE;
               off_q <= off_w;
            end else begin
               k_q <= k_q + 1'b1;
               if (lane_end) begin
                  lane_q <= '0;
                  grp_q  <= grp_q + 1'b1;
               end else begin
                  lane_q <= lane_q + 1'b1;
               end
            end
         end
      end
   end

   p_opposite_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (hi_q != wp_hi));
   p_chan_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ({1'b0, out_chan} < (LANE_W+2)'(2 * LANES)));
   p_sample_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ({1'b0, out_sample} < (POS_W+1)'(CH_LEN)));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_chan) && $stable(out_sample) && $stable(raddr)));
   p_skip_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      skip_flag |=> skip_flag);
   p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_flag |=> overrun_flag);

endmodule

// File: rtl/ppcap_deint.sv
module ppcap_deint
   import ppcap_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int WORD_W = 32,
   parameter int GROUPS = 8,
   parameter int CH_LEN = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [WORD_W-1:0]            in_word,
   input  logic [idx_w(CH_LEN)-1:0]     rd_pos,
   output logic                         half_evt,
   output logic                         wrap_evt,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [WORD_W-1:0]            out_word,
   output logic [idx_w(LANES):0]        out_chan,
   output logic [idx_w(CH_LEN)-1:0]     out_sample,
   output logic                         skip_flag,
   output logic                         overrun_flag
);
   localparam int DEPTH  = GROUPS * LANES;
   localparam int AW     = idx_w(DEPTH);
   localparam int LANE_W = idx_w(LANES);
   localparam int GW     = idx_w(GROUPS / 2);
   localparam int POS_W  = idx_w(CH_LEN);

   initial begin : chk_params
      assert (LANES >= 1) else $error("LANES must be at least 1");
      assert (GROUPS >= 4 && GROUPS % 4 == 0) else $error("GROUPS must be a multiple of 4");
      assert (CH_LEN >= 2) else $error("CH_LEN must be at least 2");
      assert (GROUPS / 4 <= CH_LEN) else $error("one half must fit in a channel buffer");
   end

   logic [AW-1:0] wp, raddr;
   logic          wp_hi, wr_en, busy, drain_hi;

   ppcap_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .busy     (busy),
      .drain_hi (drain_hi),
      .wp       (wp),
      .wp_hi    (wp_hi),
      .wr_en    (wr_en),
      .half_evt (half_evt),
      .wrap_evt (wrap_evt)
   );

   ppcap_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wp),
      .wdata (in_word),
      .raddr (raddr),
      .rdata (out_word)
   );

   ppcap_drain #(
      .LANES(LANES), .GROUPS(GROUPS), .CH_LEN(CH_LEN),
      .AW(AW), .LANE_W(LANE_W), .GW(GW), .POS_W(POS_W)
   ) u_drain (
      .clk          (clk),
      .rst_n        (rst_n),
      .half_evt     (half_evt),
      .wrap_evt     (wrap_evt),
      .wp_hi        (wp_hi),
      .rd_pos       (rd_pos),
      .out_ready    (out_ready),
      .busy         (busy),
      .drain_hi     (drain_hi),
      .raddr        (raddr),
      .out_valid    (out_valid),
      .out_chan     (out_chan),
      .out_sample   (out_sample),
      .skip_flag    (skip_flag),
      .overrun_flag (overrun_flag)
   );

endmodule

// File: tb/tb_ppcap_deint.sv
`timescale 1ns/1ps
module tb_ppcap_deint;
   localparam int LANES  = 2;
   localparam int WORD_W = 32;
   localparam int GROUPS = 8;
   localparam int CH_LEN = 16;
   localparam int DEPTH  = GROUPS * LANES;
   localparam int HALF   = DEPTH / 2;
   localparam int SPH    = GROUPS / 4;
   localparam int POS_W  = 4;
   localparam int CH_W   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              in_valid = 1'b0;
   logic [WORD_W-1:0] in_word = '0;
   logic [POS_W-1:0]  rd_pos = '0;
   logic              out_ready = 1'b0;
   logic              half_evt, wrap_evt, out_valid, skip_flag, overrun_flag;
   logic [WORD_W-1:0] out_word;
   logic [CH_W-1:0]   out_chan;
   logic [POS_W-1:0]  out_sample;

   ppcap_deint #(.LANES(LANES), .WORD_W(WORD_W), .GROUPS(GROUPS), .CH_LEN(CH_LEN)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .rd_pos(rd_pos),
      .half_evt(half_evt), .wrap_evt(wrap_evt), .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word), .out_chan(out_chan), .out_sample(out_sample),
      .skip_flag(skip_flag), .overrun_flag(overrun_flag)
   );

   int checks = 0;
   int errors = 0;

   // Behavioural reference: memory image, pointer, expected output queue.
   typedef struct {
      bit [WORD_W-1:0] word;
      int chan;
      int samp;
      int k;
   } ent_t;
   ent_t q[$];
   bit [WORD_W-1:0] m_mem [DEPTH];
   int  m_wp = 0, m_off = 0, m_hi = 0;
   bit  m_hevt = 0, m_wevt = 0, m_skip = 0, m_ovr = 0;
   bit  hold_prev = 0;
   bit [WORD_W-1:0] pw;
   int  pc, ps;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk(half_evt === m_hevt, "R2 half_evt", longint'(half_evt), longint'(m_hevt));
      chk(wrap_evt === m_wevt, "R2 wrap_evt", longint'(wrap_evt), longint'(m_wevt));
      chk(out_valid === (q.size() > 0), "R3 out_valid", longint'(out_valid), longint'(q.size() > 0));
      if (out_valid === 1'b1 && q.size() > 0) begin
         chk(out_word === q[0].word, "R1 R10 out_word", longint'(out_word), longint'(q[0].word));
         chk(int'(out_chan) == q[0].chan, "R4 out_chan", longint'(out_chan), longint'(q[0].chan));
         chk(int'(out_sample) == q[0].samp, (q[0].k == 0) ? "R6 drain offset" : "R5 out_sample",
             longint'(out_sample), longint'(q[0].samp));
      end
      if (hold_prev) begin
         chk(out_word === pw && int'(out_chan) == pc && int'(out_sample) == ps,
             "R8 held output", longint'(out_word), longint'(pw));
      end
      chk(skip_flag === m_skip, "R7 skip_flag", longint'(skip_flag), longint'(m_skip));
      chk(overrun_flag === m_ovr, "R9 overrun_flag", longint'(overrun_flag), longint'(m_ovr));
   endtask

   task automatic step(input bit iv, input bit [WORD_W-1:0] iw, input bit rdy, input int rpos);
      bit was_busy = (q.size() > 0);
      bit evt = m_hevt || m_wevt;
      if (was_busy && rdy) begin
         void'(q.pop_front());
         if (q.size() == 0) m_off = (m_off + SPH) % CH_LEN;
      end
      if (evt) begin
         if (was_busy) m_ovr = 1;
         else if (m_off < rpos && m_off + SPH >= rpos) m_skip = 1;
         else begin
            m_hi = (m_wp >= HALF) ? 0 : 1;
            for (int k = 0; k < HALF; k++) begin
               ent_t e;
               e.word = m_mem[m_hi * HALF + k];
               e.chan = 2 * (k % LANES) + ((k / LANES) % 2);
               e.samp = (m_off + (k / LANES) / 2) % CH_LEN;
               e.k    = k;
               q.push_back(e);
            end
         end
      end
      m_hevt = iv && (m_wp == HALF - 1);
      m_wevt = iv && (m_wp == DEPTH - 1);
      if (iv) begin
         if (!(was_busy && (((m_wp >= HALF) ? 1 : 0) == m_hi))) m_mem[m_wp] = iw;
         m_wp = (m_wp == DEPTH - 1) ? 0 : m_wp + 1;
      end
   endtask

   task automatic cyc(input bit iv, input bit [WORD_W-1:0] iw, input bit rdy, input int rpos);
      @(negedge clk);
      compare();
      in_valid  = iv;
      in_word   = iw;
      out_ready = rdy;
      rd_pos    = POS_W'(rpos);
      hold_prev = (out_valid === 1'b1) && !rdy;
      pw = out_word;
      pc = int'(out_chan);
      ps = int'(out_sample);
      step(iv, iw, rdy, rpos);
   endtask

   initial begin : watchdog
      #(4 * 100000);
      errors++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(out_valid === 1'b0, "R11 out_valid", longint'(out_valid), 0);
      chk(half_evt === 1'b0, "R11 half_evt", longint'(half_evt), 0);
      chk(wrap_evt === 1'b0, "R11 wrap_evt", longint'(wrap_evt), 0);
      chk(skip_flag === 1'b0, "R11 skip_flag", longint'(skip_flag), 0);
      chk(overrun_flag === 1'b0, "R11 overrun_flag", longint'(overrun_flag), 0);
      rst_n = 1'b1;
      // Normal drains, slow writer, consumer stalls one cycle in four.
      for (int c = 0; c < 1200; c++) cyc(c % 3 == 0, $urandom, (c % 4) != 3, 0);
      // Reader just ahead of the offset: every drain must be skipped (R7).
      for (int c = 0; c < 600; c++) cyc(c % 3 == 0, $urandom, (c % 4) != 3, (m_off + 1) % CH_LEN);
      // Brisk writer with the consumer always ready.
      for (int c = 0; c < 400; c++) cyc(c % 2 == 0, $urandom, 1'b1, 0);
      // Starved consumer: overrun (R9) and discarded writes (R10).
      for (int c = 0; c < 600; c++) cyc(1'b1, $urandom, (c % 16) == 0, 0);
      for (int c = 0; c < 200; c++) cyc(1'b0, '0, 1'b1, 0);
      @(negedge clk);
      compare();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule